// File: doc/BRIEF.md
# Multi-Channel Compare-Match Event Timer

This block is a register-mapped event timer. A single main counter advances by one each clock while a global run bit is set and holds its value while it is clear. A parameterized set of compare channels watches that counter. Each channel raises its own interrupt line when the counter reaches the channel's compare value.

A channel runs in one of two ways. In single-shot mode it fires once per pass of the counter. In repeating mode it adds a stored interval to its compare value after every match. The interrupt can be a latched level, which software acknowledges by writing a one to the status register, or a pulse one clock long. Software accesses the block through a 64-bit register port with separate read and write strobes and a byte offset. Read data is combinational and is driven only while the read strobe is high.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, the global configuration, the status register, all channel configuration bits that can be written, and every interval read as zero. Every compare value reads as all ones and every interrupt line is low.
- R2: Offset 0x000 reads the tick period in bits 63:32, a vendor code in bits 31:16, a one in bit 15, a zero in bit 14, a one in bit 13, the channel count minus one in bits 12:8 and a revision code in bits 7:0.
- R3: The counter at offset 0x0F0 increments by exactly one per clock while bit 0 of the global configuration (offset 0x010) is 1, and holds its value while that bit is 0. Bit 1 of that register is stored and reads back, and it has no other effect.
- R4: Channel N's configuration register is at 0x100+0x20*N and its compare register at 0x108+0x20*N. Status is at 0x020. Every offset not listed in R2 through R4 reads as zero.
- R5: In a channel configuration register, bit 1 selects level (1) or pulse (0), bit 2 enables the interrupt, bit 3 requests repeating mode, bit 4 reads the channel's repeat capability, bit 5 reads 1, bit 6 is the interval-load flag, bit 8 selects 32-bit mode, and bits 13:9 are a stored route number. On a channel without repeat capability, bit 3 reads 0 and the channel behaves as single-shot.
- R6: A match is taken in a cycle where the run bit is 1 and the counter equals the compare value. The effects of a match are visible on the next clock. A single-shot channel fires once per pass and does not fire again while the counter continues.
- R7: In repeating mode, a compare write with bit 6 set loads both the compare value and the interval, then clears bit 6. A compare write with bit 6 clear sets only the next match point. Each match adds the interval to the compare value.
- R8: A write to the counter offset loads the counter on the next clock, taking priority over counting.
- R9: A match on a level channel sets that channel's status bit regardless of its interrupt enable. Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. The level interrupt line equals the status bit AND the enable bit.
- R10: A pulse channel with its enable set drives its line high for exactly one clock after a match and leaves its status bit at zero.
- R11: In 32-bit mode, a compare write zeroes the upper 32 bits and matching compares only the lower 32 bits of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, combinational, zero when rd_en is low |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
The bench builds the block with three channels, with repeat capability on channel 0 only and the default 12-bit offset. This covers three cases: a repeat-capable channel, a channel that has to ignore a repeat request, and a 32-bit-mode channel whose compare upper bits differ from the counter's. The counter is sampled every clock through the read port across repeated passes. Every expected pulse position is computed arithmetically from the loaded compare value and interval, so each fire point and each silent cycle in the sweep is checked.

// File: rtl/evt_pkg.sv
package evt_pkg;
   // register offsets (bytes)
   localparam int OFF_CAP    = 'h000;
   localparam int OFF_GCFG   = 'h010;
   localparam int OFF_STAT   = 'h020;
   localparam int OFF_CNT    = 'h0F0;
   localparam int CH_BASE    = 'h100;
   localparam int CH_STRIDE  = 'h20;
   localparam int CH_CMP_OFS = 'h08;
   // channel configuration bit positions
   localparam int B_LEVEL = 1;
   localparam int B_IE    = 2;
   localparam int B_REP   = 3;
   localparam int B_RCAP  = 4;
   localparam int B_WCAP  = 5;
   localparam int B_VLOAD = 6;
   localparam int B_M32   = 8;
   localparam int B_RT_LO = 9;
   localparam int B_RT_HI = 13;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (run) cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
   import evt_pkg::*;
#(
   parameter bit REP_CAP = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic [63:0] cnt,
   input  logic        cfg_we,
   input  logic        cmp_we,
   input  logic [63:0] wdata,
   input  logic        stat_clr,
   output logic [63:0] cfg_rd,
   output logic [63:0] cmp_rd,
   output logic        hit,
   output logic        stat,
   output logic        irq
);
   logic        level_q, ie_q, vload_q, m32_q, pulse_q;
   logic [4:0]  route_q;
   logic [63:0] cmp_q, ival_q, wval, next_cmp;
   logic        rep;

   generate
      if (REP_CAP) begin : g_rep
         logic rep_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rep_q <= 1'b0;
            else if (cfg_we) rep_q <= wdata[B_REP];
         end
         assign rep = rep_q;
      end else begin : g_norep
         assign rep = 1'b0;
      end
   endgenerate

   assign wval     = m32_q ? {32'b0, wdata[31:0]} : wdata;
   assign next_cmp = m32_q ? {32'b0, cmp_q[31:0] + ival_q[31:0]} : cmp_q + ival_q;
   assign hit      = run && (m32_q ? (cnt[31:0] == cmp_q[31:0]) : (cnt == cmp_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0; ie_q <= 1'b0; vload_q <= 1'b0; m32_q <= 1'b0;
         route_q <= '0;
      end else if (cfg_we) begin
         level_q <= wdata[B_LEVEL];
         ie_q    <= wdata[B_IE];
         vload_q <= wdata[B_VLOAD];
         m32_q   <= wdata[B_M32];
         route_q <= wdata[B_RT_HI:B_RT_LO];
      end else if (cmp_we && rep && vload_q) begin
         vload_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '1;
         ival_q <= '0;
      end else if (cmp_we) begin
         cmp_q <= wval;
         if (rep && vload_q) ival_q <= wval;
      end else if (hit && rep) begin
         cmp_q <= next_cmp;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat    <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (hit && level_q) stat <= 1'b1;
         else if (stat_clr)  stat <= 1'b0;
         pulse_q <= hit && ie_q && !level_q;
      end
   end

   assign irq    = level_q ? (stat && ie_q) : pulse_q;
   assign cmp_rd = cmp_q;
   assign cfg_rd = {32'b0, 18'b0, route_q, m32_q, 1'b0, vload_q, 1'b1,
                    REP_CAP, rep, ie_q, level_q, 1'b0};
endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_pkg::*;
#(
   parameter int          NUM_CH    = 3,
   parameter int          ADDR_W    = 12,
   parameter logic [31:0] TICK_FS   = 32'd69841279,
   parameter logic [15:0] VENDOR    = 16'h5A17,
   parameter logic [7:0]  REV       = 8'h01,
   parameter logic [31:0] REP_MASK  = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wdata,
   output logic [63:0]       rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int MAP_END = CH_BASE + CH_STRIDE * NUM_CH;
   localparam logic [4:0] CH_FIELD = 5'(NUM_CH - 1);

   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("evt_timer: NUM_CH must be 1..32");
      end
      if (MAP_END > (1 << ADDR_W)) begin : g_bad_aw
         $error("evt_timer: ADDR_W too small for channel map");
      end
   endgenerate

   logic              run_q, leg_q, ld;
   logic [63:0]       cnt;
   logic [NUM_CH-1:0] stat, hit, clr, cfg_we, cmp_we;
   logic [63:0]       cfg_rd [NUM_CH];
   logic [63:0]       cmp_rd [NUM_CH];
   logic [63:0]       cap;

   assign cap = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, CH_FIELD, REV};
   assign ld  = wr_en && (addr == ADDR_W'(OFF_CNT));
   assign clr = (wr_en && (addr == ADDR_W'(OFF_STAT))) ? wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         leg_q <= 1'b0;
      end else if (wr_en && (addr == ADDR_W'(OFF_GCFG))) begin
         run_q <= wdata[0];
         leg_q <= wdata[1];
      end
   end

   evt_counter #(.W(64)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q), .ld(ld), .ld_val(wdata), .cnt(cnt)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign cfg_we[i] = wr_en && (addr == ADDR_W'(CH_BASE + CH_STRIDE * i));
         assign cmp_we[i] = wr_en && (addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_CMP_OFS));
         evt_channel #(.REP_CAP(REP_MASK[i])) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt),
            .cfg_we(cfg_we[i]), .cmp_we(cmp_we[i]), .wdata(wdata),
            .stat_clr(clr[i]), .cfg_rd(cfg_rd[i]), .cmp_rd(cmp_rd[i]),
            .hit(hit[i]), .stat(stat[i]), .irq(irq[i])
         );
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == ADDR_W'(OFF_CAP))  rdata = cap;
         if (addr == ADDR_W'(OFF_GCFG)) rdata = {62'b0, leg_q, run_q};
         if (addr == ADDR_W'(OFF_STAT)) rdata = 64'(stat);
         if (addr == ADDR_W'(OFF_CNT))  rdata = cnt;
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(CH_BASE + CH_STRIDE * i))              rdata = cfg_rd[i];
            if (addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_CMP_OFS)) rdata = cmp_rd[i];
         end
      end
   end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
   import evt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [63:0]       wdata,
   input logic              run,
   input logic [63:0]       cnt,
   input logic [NUM_CH-1:0] stat,
   input logic [NUM_CH-1:0] hit
);
   logic ld_w, st_w;
   assign ld_w = wr_en && (addr == ADDR_W'(OFF_CNT));
   assign st_w = wr_en && (addr == ADDR_W'(OFF_STAT));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_w) |=> $stable(cnt));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_w) |=> (cnt == $past(cnt) + 64'd1));

   // R8
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w |=> (cnt == $past(wdata)));

   // R9
   stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_w |=> ((stat & $past(wdata[NUM_CH-1:0]) & ~$past(hit)) == '0));

   // R6
   stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> ((stat & ~$past(stat)) == '0));
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .run(run_q), .cnt(cnt), .stat(stat), .hit(hit)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
   localparam int          NCH  = 3;
   localparam int          AW   = 12;
   localparam logic [31:0] TICK = 32'd69841279;
   localparam logic [15:0] VEND = 16'h5A17;
   localparam logic [7:0]  RV   = 8'h01;

   logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [63:0]   wdata = '0, rdata;
   logic [NCH-1:0] irq;
   int checks = 0, fails = 0, cycles = 0;

   always #2.5 clk = ~clk;

   evt_timer #(.NUM_CH(NCH), .ADDR_W(AW), .TICK_FS(TICK), .VENDOR(VEND),
               .REV(RV), .REP_MASK(32'h1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [63:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   function automatic int cfg_a(input int n); return 'h100 + 'h20 * n; endfunction
   function automatic int cmp_a(input int n); return 'h108 + 'h20 * n; endfunction

   // one sample per clock: counter value and irq vector
   task automatic sample(output logic [63:0] c, output logic [NCH-1:0] q);
      rd(32'h0F0, c);
      q = irq;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [63:0] v, v2, c;
      logic [NCH-1:0] q;
      int first;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      chk("R1 irq", 64'(irq), 64'd0);
      rd('h010, v); chk("R1 gcfg", v, 64'd0);
      rd('h020, v); chk("R1 status", v, 64'd0);
      rd('h0F0, v); chk("R1 counter", v, 64'd0);
      for (int n = 0; n < NCH; n++) begin
         rd(cmp_a(n), v); chk("R1 compare", v, '1);
         rd(cfg_a(n), v); chk("R1 cfg", v, (n == 0) ? 64'h30 : 64'h20);
      end

      // R2 capability
      rd('h000, v);
      chk("R2 cap", v, {TICK, VEND, 8'hA0 | 8'(NCH - 1), RV});

      // R4 unmapped offsets
      rd('h008, v); chk("R4 unmapped 008", v, 64'd0);
      rd('h0F8, v); chk("R4 unmapped 0F8", v, 64'd0);
      rd('h110, v); chk("R4 unmapped 110", v, 64'd0);
      rd('h3F8, v); chk("R4 unmapped 3F8", v, 64'd0);

      // R5 config field mask, repeat ignored on non-capable channel
      wr(cfg_a(0), '1); rd(cfg_a(0), v); chk("R5 ch0 cfg", v, 64'h3F7E);
      wr(cfg_a(1), '1); rd(cfg_a(1), v); chk("R5 ch1 cfg", v, 64'h3F66);
      for (int n = 0; n < NCH; n++) wr(cfg_a(n), 64'd0);

      // R3/R8 counter load, freeze, run
      wr('h0F0, 64'd100);
      repeat (10) @(posedge clk);
      rd('h0F0, v); chk("R8 load / R3 frozen", v, 64'd100);
      wr('h010, 64'd2);
      rd('h010, v); chk("R3 gcfg bit1 readback", v, 64'd2);
      repeat (5) @(posedge clk);
      rd('h0F0, v); chk("R3 bit1 does not run", v, 64'd100);
      wr('h010, 64'd1);
      rd('h0F0, v);
      repeat (17) @(posedge clk);
      rd('h0F0, v2); chk("R3 step count", v2 - v, 64'd17);
      wr('h010, 64'd0);
      rd('h0F0, v);
      repeat (9) @(posedge clk);
      rd('h0F0, v2); chk("R3 frozen after disable", v2, v);

      // R6/R9 single-shot level channel 1
      wr('h0F0, 64'd0);
      wr(cfg_a(1), 64'h6);
      wr(cmp_a(1), 64'd20);
      wr('h010, 64'd1);
      first = -1;
      for (int k = 0; k < 40; k++) begin
         sample(c, q);
         if (q[1] && first < 0) first = int'(c);
      end
      chk("R6 fire point", 64'(first), 64'd21);
      rd('h020, v); chk("R9 status set", v, 64'd2);
      wr('h020, 64'd0);
      rd('h020, v); chk("R9 write zero no effect", v, 64'd2);
      wr(cfg_a(1), 64'h2);
      chk("R9 irq masked by enable", 64'(irq[1]), 64'd0);
      rd('h020, v); chk("R9 status kept when masked", v, 64'd2);
      wr(cfg_a(1), 64'h6);
      chk("R9 irq follows status", 64'(irq[1]), 64'd1);
      wr('h020, 64'd2);
      rd('h020, v); chk("R9 W1C clears", v, 64'd0);
      chk("R9 irq low after clear", 64'(irq[1]), 64'd0);
      for (int k = 0; k < 60; k++) begin
         sample(c, q);
         chk("R6 single-shot stays quiet", 64'(q[1]), 64'd0);
      end
      wr(cfg_a(1), 64'd0);

      // R7/R10 repeating pulse channel 0, interval 10
      wr('h010, 64'd0);
      wr('h0F0, 64'd0);
      wr(cfg_a(0), 64'h4C);
      wr(cmp_a(0), 64'd10);
      rd(cfg_a(0), v); chk("R7 interval-load flag cleared", v, 64'h3C);
      wr('h010, 64'd1);
      for (int k = 0; k < 100; k++) begin
         sample(c, q);
         chk("R7 R10 repeat pulse", 64'(q[0]), 64'(c >= 11 && (c - 11) % 10 == 0));
      end
      rd('h020, v); chk("R10 pulse leaves status", v, 64'd0);

      // R7 compare write without flag moves only the match point
      wr('h010, 64'd0);
      wr('h0F0, 64'd0);
      wr(cmp_a(0), 64'd55);
      wr('h010, 64'd1);
      for (int k = 0; k < 90; k++) begin
         sample(c, q);
         chk("R7 match point only", 64'(q[0]), 64'(c >= 56 && (c - 56) % 10 == 0));
      end

      // R5 channel 2 ignores repeat request
      wr('h010, 64'd0);
      wr(cfg_a(0), 64'd0);
      wr('h0F0, 64'd0);
      wr(cfg_a(2), 64'h0C);
      rd(cfg_a(2), v); chk("R5 repeat bit reads 0", v, 64'h24);
      wr(cmp_a(2), 64'd5);
      wr('h010, 64'd1);
      for (int k = 0; k < 40; k++) begin
         sample(c, q);
         chk("R5 non-capable single-shot", 64'(q[2]), 64'(c == 6));
      end

      // R11 32-bit mode on channel 2
      wr('h010, 64'd0);
      wr(cfg_a(2), 64'h104);
      wr(cmp_a(2), 64'hABCD_0000_0000_0030);
      rd(cmp_a(2), v); chk("R11 upper bits zeroed", v, 64'h30);
      wr('h0F0, 64'h0000_0005_0000_0020);
      wr('h010, 64'd1);
      for (int k = 0; k < 40; k++) begin
         sample(c, q);
         chk("R11 low-half match", 64'(q[2]), 64'(c == 64'h0000_0005_0000_0031));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule